// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block supervises data and control hazards for an in-order, five-stage integer pipeline: fetch, decode, execute, memory and writeback. It looks at the instruction word held between fetch and decode. It also looks at the register numbers and control flags carried by the three later stage registers. From these it chooses where each operand comes from, decides when the front of the pipeline must wait, and decides when a fetched instruction must be thrown away.

Read-after-write is the only hazard it handles. Register reads all happen in decode and register writes all happen in writeback, so write-after-read and write-after-write cannot arise. A result that already sits in a later stage is forwarded instead of waited for. A loaded value used by the very next instruction costs one bubble. Branches test one register against zero in decode. A taken branch costs one slot, and that slot is discarded unless the delay-slot mode is on.

A small state machine records the action taken on the previous cycle. Its states are S_FLOW (no intervention), S_LOAD_WAIT (a load-use bubble was inserted), S_BR_WAIT (a branch waited for its operand) and S_SQUASH (the slot after a taken branch was discarded). On every clock it moves to the state that names the current cycle's action. Load-use wins over branch wait, branch wait wins over squash, and otherwise it returns to S_FLOW. All control outputs are combinational from the current inputs, so they act in the same cycle.

Top module: `hz_ctrl_top`

## Requirements
- R1: The decode-stage word is split as opcode = bits 31:26, first source = bits 25:21, second source = bits 20:16. Opcode 0x00 (register-register) and 0x2B (store) read both sources. Opcode 0x04 (branch if zero) and 0x05 (branch if not zero) are branches that read the first source only. Opcode 0x02 (jump) reads no register. Every other opcode reads the first source only, so bits 20:16 of an immediate-form word (its destination) never count as a source.
- R2: An execute-stage operand select is 2'b10 when the execute/memory stage writes a register, is not a load, and its destination equals that operand's nonzero source number.
- R3: Otherwise the select is 2'b01 when the memory/writeback stage writes a register whose nonzero destination equals the source number. When neither applies it is 2'b00 (register file).
- R4: When both later stages match the same source, the execute/memory stage (2'b10) is chosen.
- R5: Register 0 is never forwarded and never causes a stall.
- R6: When the execute stage holds a load with a nonzero destination that equals a source read by the decode-stage instruction, pc_hold, ifid_hold and idex_bubble are all 1 in that same cycle.
- R7: A load whose destination matches only a field that the decode-stage instruction does not read (R1) causes no stall.
- R8: A branch in decode stalls (all three hold/bubble outputs 1) when its nonzero source equals the destination of a register-writing instruction in execute, or of a load in the memory stage.
- R9: The branch operand select br_fwd_sel uses the same encoding and priority as R2 to R4, so a load in the memory stage is never its source.
- R10: A branch in decode that is not stalled and whose zero test is true (br_cond_true = 1) raises ifid_squash, with no hold or bubble. A false test or a stalled branch gives no squash.
- R11: With delay_slot_en = 1, ifid_squash is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the action-tracking state |
| delay_slot_en | input | 1 | 1: the slot after a taken branch executes |
| ifid_instr | input | 32 | Instruction in the decode stage |
| br_cond_true | input | 1 | Outcome of the decode-stage zero test |
| idex_rs1 | input | 5 | First source of the execute-stage instruction |
| idex_rs2 | input | 5 | Second source of the execute-stage instruction |
| idex_rd | input | 5 | Destination of the execute-stage instruction |
| idex_reg_write | input | 1 | Execute-stage instruction writes a register |
| idex_mem_read | input | 1 | Execute-stage instruction is a load |
| exmem_rd | input | 5 | Destination in the memory stage |
| exmem_reg_write | input | 1 | Memory-stage instruction writes a register |
| exmem_mem_read | input | 1 | Memory-stage instruction is a load |
| memwb_rd | input | 5 | Destination in the writeback stage |
| memwb_reg_write | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_sel | output | 2 | First execute operand source (00 file, 01 writeback, 10 memory) |
| fwd_b_sel | output | 2 | Second execute operand source |
| br_fwd_sel | output | 2 | Decode-stage branch operand source |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_squash | output | 1 | Discard the instruction in the slot after a taken branch |

## Verification
The forwarding selects are driven with one match in each stage, with matches in both stages, with register 0, and with a load in the memory stage. These separate the priority rule, the zero exclusion and the load exclusion. Load-use cases place the matching register in each field of register-register, store, immediate and jump words, so that a stall on a field that is not read shows up. Branches are tried with a producer in execute, a load in the memory stage, a forwardable producer, true and false zero tests, and both slot modes. These separate a stall from a squash and a squash from the delay-slot mode.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int INSTR_W = 32;
    localparam int REG_AW  = 5;
    localparam int OP_W    = 6;

    localparam logic [OP_W-1:0] OP_RR    = 6'h00;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OP_BRZ   = 6'h04;
    localparam logic [OP_W-1:0] OP_BRNZ  = 6'h05;
    localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

    typedef enum logic [1:0] {
        SRC_FILE  = 2'b00,
        SRC_MEMWB = 2'b01,
        SRC_EXMEM = 2'b10
    } fwd_src_e;

    typedef enum logic [1:0] {
        S_FLOW      = 2'd0,
        S_LOAD_WAIT = 2'd1,
        S_BR_WAIT   = 2'd2,
        S_SQUASH    = 2'd3
    } hz_state_e;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
    import hz_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [REG_AW-1:0]  src1,
    output logic [REG_AW-1:0]  src2,
    output logic               reads1,
    output logic               reads2,
    output logic               is_branch
);
    localparam int OP_LSB   = INSTR_W - OP_W;
    localparam int S1_LSB   = OP_LSB - REG_AW;
    localparam int S2_LSB   = S1_LSB - REG_AW;

    logic [OP_W-1:0] opcode;
    logic            unused_low;

    assign opcode     = instr[INSTR_W-1:OP_LSB];
    assign src1       = instr[OP_LSB-1:S1_LSB];
    assign src2       = instr[S1_LSB-1:S2_LSB];
    assign unused_low = ^instr[S2_LSB-1:0];

    always_comb begin
        reads1    = 1'b1;
        reads2    = 1'b0;
        is_branch = 1'b0;
        unique case (opcode)
            OP_RR, OP_STORE: reads2 = 1'b1;
            OP_JUMP:         reads1 = 1'b0;
            OP_BRZ, OP_BRNZ: is_branch = 1'b1;
            default:         reads2 = 1'b0;
        endcase
    end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] near_rd,
    input  logic              near_ok,
    input  logic [REG_AW-1:0] far_rd,
    input  logic              far_ok,
    output logic [1:0]        sel
);
    logic src_live;
    assign src_live = (src != '0);

    always_comb begin
        if (src_live && near_ok && near_rd == src)
            sel = SRC_EXMEM;
        else if (src_live && far_ok && far_rd == src)
            sel = SRC_MEMWB;
        else
            sel = SRC_FILE;
    end

    // R5: register 0 is never a forwarding source
    p_no_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SRC_FILE) |-> (src != '0));
    // R4: nearer stage wins when both match
    p_near_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (near_ok && far_ok && near_rd == far_rd && near_rd == src && src != '0)
        |-> (sel == SRC_EXMEM));
endmodule

// File: rtl/hz_stall_fsm.sv
module hz_stall_fsm
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              delay_slot_en,
    input  logic [REG_AW-1:0] src1,
    input  logic [REG_AW-1:0] src2,
    input  logic              reads1,
    input  logic              reads2,
    input  logic              is_branch,
    input  logic              br_cond_true,
    input  logic [REG_AW-1:0] idex_rd,
    input  logic              idex_reg_write,
    input  logic              idex_mem_read,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              exmem_mem_read,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble,
    output logic              ifid_squash
);
    hz_state_e state, next_state;
    logic load_use, br_wait, br_taken;

    always_comb begin
        load_use = idex_mem_read && (idex_rd != '0) &&
                   ((reads1 && src1 == idex_rd) || (reads2 && src2 == idex_rd));
        br_wait  = is_branch && (src1 != '0) &&
                   ((idex_reg_write && idex_rd == src1) ||
                    (exmem_mem_read && exmem_rd == src1));
        br_taken = is_branch && br_cond_true && !br_wait && !load_use;

        if (load_use)                        next_state = S_LOAD_WAIT;
        else if (br_wait)                    next_state = S_BR_WAIT;
        else if (br_taken && !delay_slot_en) next_state = S_SQUASH;
        else                                 next_state = S_FLOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FLOW;
        else        state <= next_state;
    end

    always_comb begin
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        idex_bubble = 1'b0;
        ifid_squash = 1'b0;
        unique case (next_state)
            S_LOAD_WAIT, S_BR_WAIT: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
            end
            S_SQUASH: ifid_squash = 1'b1;
            S_FLOW:   ifid_squash = 1'b0;
        endcase
    end

    // R10: a discarded slot never coincides with a hold
    p_squash_no_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_squash |-> (!pc_hold && !idex_bubble));
    // R11: delay-slot mode never discards
    p_delay_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        delay_slot_en |-> !ifid_squash);
    // R11: a recorded squash came from a cycle without delay-slot mode
    p_squash_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SQUASH) |-> !$past(delay_slot_en));
    // R10: no squash without a branch in decode
    p_squash_needs_br_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_squash |-> (is_branch && br_cond_true));
endmodule

// File: rtl/hz_ctrl_top.sv
module hz_ctrl_top
    import hz_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        delay_slot_en,
    input  logic [31:0] ifid_instr,
    input  logic        br_cond_true,
    input  logic [4:0]  idex_rs1,
    input  logic [4:0]  idex_rs2,
    input  logic [4:0]  idex_rd,
    input  logic        idex_reg_write,
    input  logic        idex_mem_read,
    input  logic [4:0]  exmem_rd,
    input  logic        exmem_reg_write,
    input  logic        exmem_mem_read,
    input  logic [4:0]  memwb_rd,
    input  logic        memwb_reg_write,
    output logic [1:0]  fwd_a_sel,
    output logic [1:0]  fwd_b_sel,
    output logic [1:0]  br_fwd_sel,
    output logic        pc_hold,
    output logic        ifid_hold,
    output logic        idex_bubble,
    output logic        ifid_squash
);
    localparam int N_SRC = 3;

    logic [REG_AW-1:0] id_src1, id_src2;
    logic              id_reads1, id_reads2, id_branch;
    logic              near_ok;
    logic [REG_AW-1:0] srcs [N_SRC];
    logic [1:0]        sels [N_SRC];

    hz_decode u_dec (
        .instr     (ifid_instr),
        .src1      (id_src1),
        .src2      (id_src2),
        .reads1    (id_reads1),
        .reads2    (id_reads2),
        .is_branch (id_branch)
    );

    assign near_ok = exmem_reg_write && !exmem_mem_read;
    assign srcs[0] = idex_rs1;
    assign srcs[1] = idex_rs2;
    assign srcs[2] = id_src1;

    for (genvar g = 0; g < N_SRC; g++) begin : g_fwd
        hz_fwd_sel u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (srcs[g]),
            .near_rd (exmem_rd),
            .near_ok (near_ok),
            .far_rd  (memwb_rd),
            .far_ok  (memwb_reg_write),
            .sel     (sels[g])
        );
    end

    assign fwd_a_sel  = sels[0];
    assign fwd_b_sel  = sels[1];
    assign br_fwd_sel = sels[2];

    hz_stall_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .delay_slot_en  (delay_slot_en),
        .src1           (id_src1),
        .src2           (id_src2),
        .reads1         (id_reads1),
        .reads2         (id_reads2),
        .is_branch      (id_branch),
        .br_cond_true   (br_cond_true),
        .idex_rd        (idex_rd),
        .idex_reg_write (idex_reg_write),
        .idex_mem_read  (idex_mem_read),
        .exmem_rd       (exmem_rd),
        .exmem_mem_read (exmem_mem_read),
        .pc_hold        (pc_hold),
        .ifid_hold      (ifid_hold),
        .idex_bubble    (idex_bubble),
        .ifid_squash    (ifid_squash)
    );

    // R9: a load in the memory stage never feeds the branch test
    p_br_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exmem_mem_read |-> (br_fwd_sel != 2'b10));
    // R8: a branch waiting on execute is held, not resolved
    p_br_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (id_branch && id_src1 != '0 && idex_reg_write && idex_rd == id_src1)
        |-> (pc_hold && !ifid_squash));
endmodule

// File: tb/sim_hz_ctrl_top.sv
`timescale 1ns/1ps
module sim_hz_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        delay_slot_en = 1'b0;
    logic [31:0] ifid_instr = '0;
    logic        br_cond_true = 1'b0;
    logic [4:0]  idex_rs1 = '0, idex_rs2 = '0, idex_rd = '0;
    logic        idex_reg_write = 1'b0, idex_mem_read = 1'b0;
    logic [4:0]  exmem_rd = '0;
    logic        exmem_reg_write = 1'b0, exmem_mem_read = 1'b0;
    logic [4:0]  memwb_rd = '0;
    logic        memwb_reg_write = 1'b0;
    logic [1:0]  fwd_a_sel, fwd_b_sel, br_fwd_sel;
    logic        pc_hold, ifid_hold, idex_bubble, ifid_squash;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hz_ctrl_top u0 (.*);

    // Reference selection: ordered stage search from the requirements
    function automatic logic [1:0] ref_sel(input logic [4:0] s);
        if (s == 0) return 2'b00;
        if (exmem_reg_write && !exmem_mem_read && exmem_rd == s) return 2'b10;
        if (memwb_reg_write && memwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic check(input string req);
        int op, a, b;
        bit r1, r2, br, lu, bw, hold, sq;
        logic [9:0] exp_v, got_v;
        @(negedge clk);
        op = int'(ifid_instr[31:26]);
        a  = int'(ifid_instr[25:21]);
        b  = int'(ifid_instr[20:16]);
        r1 = (op != 2);
        r2 = (op == 0) || (op == 'h2B);
        br = (op == 4) || (op == 5);
        lu = idex_mem_read && idex_rd != 0 &&
             ((r1 && a == idex_rd) || (r2 && b == idex_rd));
        bw = br && a != 0 && ((idex_reg_write && idex_rd == a) ||
                              (exmem_mem_read && exmem_rd == a));
        hold = lu || bw;
        sq = br && br_cond_true && !hold && !delay_slot_en;
        exp_v = {ref_sel(idex_rs1), ref_sel(idex_rs2), ref_sel(5'(a)),
                 hold, hold, hold, sq};
        got_v = {fwd_a_sel, fwd_b_sel, br_fwd_sel,
                 pc_hold, ifid_hold, idex_bubble, ifid_squash};
        checks++;
        if (got_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, got_v, exp_v);
        end
    endtask

    task automatic clear();
        delay_slot_en = 0; ifid_instr = '0; br_cond_true = 0;
        idex_rs1 = 0; idex_rs2 = 0; idex_rd = 0;
        idex_reg_write = 0; idex_mem_read = 0;
        exmem_rd = 0; exmem_reg_write = 0; exmem_mem_read = 0;
        memwb_rd = 0; memwb_reg_write = 0;
    endtask

    function automatic logic [31:0] enc(input int op, input int a, input int b, input int c);
        return {6'(op), 5'(a), 5'(b), 5'(c), 11'd0};
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        check("R1 reset");
        @(negedge clk); rst_n = 1'b1;
        // R1 register-register word with no hazards
        ifid_instr = enc(0, 1, 2, 3); check("R1");
        // R2 execute/memory forward
        clear(); idex_rs1 = 1; exmem_rd = 1; exmem_reg_write = 1; check("R2");
        // R3 memory/writeback forward on second operand
        clear(); idex_rs2 = 4; memwb_rd = 4; memwb_reg_write = 1; check("R3");
        // R4 both match: nearer wins
        clear(); idex_rs1 = 7; idex_rs2 = 7; exmem_rd = 7; exmem_reg_write = 1;
        memwb_rd = 7; memwb_reg_write = 1; check("R4");
        // R5 register 0 never forwarded
        clear(); exmem_reg_write = 1; memwb_reg_write = 1; check("R5");
        // R2 load in memory stage is skipped
        clear(); idex_rs1 = 1; exmem_rd = 1; exmem_reg_write = 1; exmem_mem_read = 1;
        memwb_rd = 1; memwb_reg_write = 1; check("R2 load skip");
        // R6 load-use on second source of register-register
        clear(); idex_mem_read = 1; idex_reg_write = 1; idex_rd = 5;
        ifid_instr = enc(0, 2, 5, 6); check("R6");
        // R6 load-use on store data source
        ifid_instr = enc('h2B, 3, 5, 0); check("R6 store");
        // R7 immediate form: bits 20:16 are a destination
        ifid_instr = enc('h08, 2, 5, 0); check("R7 imm");
        // R7 jump reads nothing
        ifid_instr = enc(2, 5, 5, 0); check("R7 jump");
        // R5 load to register 0
        clear(); idex_mem_read = 1; idex_reg_write = 1; idex_rd = 0;
        ifid_instr = enc(0, 0, 0, 1); check("R5 load");
        // R8 branch waits on execute producer
        clear(); ifid_instr = enc(4, 3, 0, 0); idex_rd = 3; idex_reg_write = 1;
        br_cond_true = 1; check("R8 ex");
        // R8 branch waits on load in memory stage
        clear(); ifid_instr = enc(4, 3, 0, 0); exmem_rd = 3; exmem_reg_write = 1;
        exmem_mem_read = 1; br_cond_true = 1; check("R8 mem load");
        // R9/R10 forwardable producer, taken: squash
        clear(); ifid_instr = enc(4, 3, 0, 0); exmem_rd = 3; exmem_reg_write = 1;
        br_cond_true = 1; check("R9 R10 taken");
        // R9/R10 writeback producer, not taken
        clear(); ifid_instr = enc(5, 3, 0, 0); memwb_rd = 3; memwb_reg_write = 1;
        check("R9 R10 not taken");
        // R10 not-zero branch taken
        clear(); ifid_instr = enc(5, 9, 0, 0); br_cond_true = 1; check("R10 bnez");
        // R11 delay-slot mode keeps the slot
        delay_slot_en = 1; check("R11");
        // R11 stalled branch in delay mode
        idex_rd = 9; idex_reg_write = 1; check("R11 stall");
        // Sequence: load-use then release after bubble
        clear(); idex_mem_read = 1; idex_reg_write = 1; idex_rd = 8;
        ifid_instr = enc(0, 8, 1, 2); check("R6 seq1");
        clear(); exmem_rd = 8; exmem_reg_write = 1; exmem_mem_read = 1;
        ifid_instr = enc(0, 8, 1, 2); check("R6 seq2");
        clear(); idex_rs1 = 8; memwb_rd = 8; memwb_reg_write = 1; check("R3 seq3");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule